// File: doc/BRIEF.md
# External Interrupt Controller with Noise Filter

This block collects four external interrupt pins, numbered line 0 to line 3, and turns them into one interrupt request with a vector address for the CPU. Every pin is first brought into the clock domain by a two-flop synchroniser. Each line then checks its own trigger condition: rising edge, falling edge, both edges, high level or low level. Which conditions a line accepts depends on the line. Edge triggers set a pending flag, and the flag stays set until the CPU acknowledges that line's vector. A level trigger simply follows the pin.

Line 3 also passes through a digital noise filter. The filter samples the pin once every 1, 16 or 64 clock cycles and accepts a new level only after two consecutive samples agree, so short glitches are dropped. Lines 2 and 3 each give a one-cycle event pulse for an external event timer. Lines 0 and 1 drive a wake output that can bring the core out of a low-power hold. Software programs the trigger modes, the enable mask and the filter rate through a small write port.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, irq_o, wake_o and tmr_evt_o are 0 and vec_o is 8'h00. After reset every line is in rising-edge mode, every line is masked, and the filter rate is 1/1. While irq_o is 0, vec_o is 8'h00.
- R2: For lines 0 to 2, an edge request shows on irq_o 3 clock edges after the pin changes: two synchroniser stages, then the pending flag. A level request shows 2 edges after the pin changes.
- R3: A write with cfg_addr_i=2 sets the mode of line cfg_wdata_i[5:4] to the code in cfg_wdata_i[2:0]. The codes are 0 rising, 1 falling, 2 both edges, 3 high level, 4 low level. Lines 0 and 1 accept codes 0, 1, 3 and 4. Lines 2 and 3 accept codes 0, 1 and 2.
- R4: A mode write with a code the addressed line does not accept is ignored, and the line keeps its previous mode. This covers code 2 on lines 0 and 1, codes 3 and 4 on lines 2 and 3, and codes 5 to 7 on any line.
- R5: An edge event sets the line's pending flag whether or not the line is enabled. The flag is cleared by ack_i when ack_vec_i equals that line's vector. An acknowledge that carries another vector has no effect on the flag.
- R6: In a level mode, the request equals the synchronised pin level: high for code 3, low for code 4. An acknowledge does not remove a level request.
- R7: A write with cfg_addr_i=0 loads the enable mask from cfg_wdata_i[3:0], with bit n enabling line n. A line that is not enabled never drives irq_o.
- R8: When several enabled lines request at once, the lowest-numbered line wins. vec_o is 8'h03, 8'h0B, 8'h13 or 8'h1B for line 0, 1, 2 or 3.
- R9: At filter rate 1/1, line 3 keeps a pin pulse of 2 or more cycles and drops a 1-cycle pulse. An edge request on line 3 shows on irq_o 5 edges after the pin changes.
- R10: A write with cfg_addr_i=1 sets the filter rate from cfg_wdata_i[1:0]: 0 gives 1/1, 1 gives 1/16, 2 gives 1/64. A write of code 3 is ignored. At 1/16, a 10-cycle pulse is dropped and a 40-cycle pulse is kept. At 1/64, a 50-cycle pulse is dropped and a 140-cycle pulse is kept.
- R11: tmr_evt_o[0] (line 2) and tmr_evt_o[1] (line 3) pulse high for one cycle when that line's edge trigger fires. The pulse comes one edge before the pending flag: 2 edges after the pin changes on line 2, and 4 edges at rate 1/1 on line 3. The pulse does not depend on the enable mask, and it follows the line's mode.
- R12: wake_o is high while enabled line 0 or line 1 has a request, or fires an edge event. It does not respond to lines 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 4 | Raw external interrupt pins, bit n is line n |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 enable mask, 1 filter rate, 2 line mode |
| cfg_wdata_i | input | 6 | Configuration write data |
| ack_i | input | 1 | CPU acknowledge strobe |
| ack_vec_i | input | 8 | Vector being acknowledged |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector address of the winning line |
| tmr_evt_o | output | 2 | Event pulses for the timer: bit 0 for line 2, bit 1 for line 3 |
| wake_o | output | 1 | Hold-release wake from lines 0 and 1 |

## Verification
Each result is checked at the exact clock edge on which it is due. A level request is due 2 edges after a pin change, and an edge request is due 3 edges after it. On line 3 at rate 1/1, the event pulse is due 4 edges after the pin change and the pending flag 5 edges after it. A configuration write or an acknowledge takes effect on the edge that samples it. The bench drives inputs and samples outputs on falling edges and counts the edges in between, so each latency check looks at the cycle just before a result is due and at the cycle it is due. At rates 1/16 and 1/64 the sampling phase depends on a free-running counter, so those checks use pulse lengths that are either below one sample period or at least two periods long, and read the result after a settling wait.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int LINES     = 4;
  localparam int FILT_LINE = 3;
  localparam int TMR_LO    = 2;
  localparam int LVL_LINES = 2;

  localparam logic [2:0] TRIG_RISE = 3'd0;
  localparam logic [2:0] TRIG_FALL = 3'd1;
  localparam logic [2:0] TRIG_BOTH = 3'd2;
  localparam logic [2:0] TRIG_HIGH = 3'd3;
  localparam logic [2:0] TRIG_LOW  = 3'd4;

  localparam logic [1:0] REG_EN   = 2'd0;
  localparam logic [1:0] REG_FILT = 2'd1;
  localparam logic [1:0] REG_MODE = 2'd2;

  localparam logic [1:0] FSEL_FAST = 2'd0;
  localparam logic [1:0] FSEL_MID  = 2'd1;
  localparam logic [1:0] FSEL_SLOW = 2'd2;

  localparam logic [7:0] VEC_BASE = 8'h03;
  localparam int         VEC_STEP = 8;

  function automatic logic [7:0] vec_of(input int idx);
    return VEC_BASE + 8'(idx * VEC_STEP);
  endfunction

  function automatic logic trig_allowed(input int line, input logic [2:0] code);
    if (line < LVL_LINES)
      return (code == TRIG_RISE) || (code == TRIG_FALL) ||
             (code == TRIG_HIGH) || (code == TRIG_LOW);
    else
      return (code == TRIG_RISE) || (code == TRIG_FALL) || (code == TRIG_BOTH);
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/eirq_filter.sv
module eirq_filter
  import ext_irq_pkg::*;
#(
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fsel_i,
  input  logic       d_i,
  output logic       q_o
);

  localparam int CW = $clog2(DIV_SLOW);
  localparam int MW = $clog2(DIV_MID);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          smp_q, smp_d;
  logic          lvl_q, lvl_d;
  logic          tick;

  // sample strobe at the selected rate
  always_comb begin
    case (fsel_i)
      FSEL_FAST: tick = 1'b1;
      FSEL_MID:  tick = &cnt_q[MW-1:0];
      default:   tick = &cnt_q;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    smp_d = smp_q;
    lvl_d = lvl_q;
    if (tick) begin
      smp_d = d_i;
      if (d_i == smp_q) lvl_d = d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      smp_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      smp_q <= smp_d;
      lvl_q <= lvl_d;
    end
  end

  assign q_o = lvl_q;

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_i,
  input  logic [2:0] mode_i,
  input  logic       clr_i,
  output logic       req_o,
  output logic       evt_o
);

  logic lvl_q, pend_q, pend_d;
  logic rise, fall;

  assign rise = lvl_i & ~lvl_q;
  assign fall = ~lvl_i & lvl_q;

  always_comb begin
    case (mode_i)
      TRIG_RISE: evt_o = rise;
      TRIG_FALL: evt_o = fall;
      TRIG_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end

  // a new event wins over a same-cycle acknowledge
  always_comb begin
    pend_d = evt_o | (pend_q & ~clr_i);
  end

  always_comb begin
    case (mode_i)
      TRIG_HIGH: req_o = lvl_i;
      TRIG_LOW:  req_o = ~lvl_i;
      default:   req_o = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_i;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter
  import ext_irq_pkg::*;
(
  input  logic [LINES-1:0] req_i,
  output logic             irq_o,
  output logic [7:0]       vec_o
);

  always_comb begin
    irq_o = |req_i;
    vec_o = 8'h00;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = vec_of(i);
    end
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_pin_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [5:0]       cfg_wdata_i,
  input  logic             ack_i,
  input  logic [7:0]       ack_vec_i,
  output logic             irq_o,
  output logic [7:0]       vec_o,
  output logic [1:0]       tmr_evt_o,
  output logic             wake_o
);

  logic [LINES-1:0]      en_q, en_d;
  logic [1:0]            fsel_q, fsel_d;
  logic [LINES-1:0][2:0] mode_q, mode_d;

  logic [LINES-1:0] syn_lvl;
  logic [LINES-1:0] det_lvl;
  logic [LINES-1:0] req;
  logic [LINES-1:0] evt;

  // configuration next state
  always_comb begin
    en_d   = en_q;
    fsel_d = fsel_q;
    mode_d = mode_q;
    if (cfg_we_i) begin
      case (cfg_addr_i)
        REG_EN:   en_d = cfg_wdata_i[LINES-1:0];
        REG_FILT: if (cfg_wdata_i[1:0] != 2'd3) fsel_d = cfg_wdata_i[1:0];
        REG_MODE: begin
          for (int l = 0; l < LINES; l++) begin
            if ((cfg_wdata_i[5:4] == 2'(l)) && trig_allowed(l, cfg_wdata_i[2:0]))
              mode_d[l] = cfg_wdata_i[2:0];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      fsel_q <= FSEL_FAST;
      mode_q <= {LINES{TRIG_RISE}};
    end else begin
      en_q   <= en_d;
      fsel_q <= fsel_d;
      mode_q <= mode_d;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (irq_pin_i[g]),
      .q_o  (syn_lvl[g])
    );

    if (g == FILT_LINE) begin : g_flt
      eirq_filter #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_flt (
        .clk   (clk),
        .rst_n (rst_n),
        .fsel_i(fsel_q),
        .d_i   (syn_lvl[g]),
        .q_o   (det_lvl[g])
      );
    end else begin : g_raw
      assign det_lvl[g] = syn_lvl[g];
    end

    eirq_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (det_lvl[g]),
      .mode_i(mode_q[g]),
      .clr_i (ack_i && (ack_vec_i == vec_of(g))),
      .req_o (req[g]),
      .evt_o (evt[g])
    );
  end

  eirq_arbiter u_arb (
    .req_i(req & en_q),
    .irq_o(irq_o),
    .vec_o(vec_o)
  );

  assign tmr_evt_o = evt[LINES-1:TMR_LO];
  assign wake_o    = |((req[LVL_LINES-1:0] | evt[LVL_LINES-1:0]) & en_q[LVL_LINES-1:0]);

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
  import ext_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq,
  input logic [7:0]            vec,
  input logic [LINES-1:0]      en,
  input logic [LINES-1:0][2:0] mode,
  input logic [1:0]            tevt,
  input logic                  flt_q,
  input logic                  flt_d
);

  a_r8_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec == 8'h03 || vec == 8'h0B || vec == 8'h13 || vec == 8'h1B));

  a_r1_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec == 8'h00));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] != TRIG_BOTH) && (mode[0] <= TRIG_LOW) &&
    (mode[1] != TRIG_BOTH) && (mode[1] <= TRIG_LOW) &&
    (mode[2] <= TRIG_BOTH) && (mode[3] <= TRIG_BOTH));

  a_r11_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
    tevt[1] |=> !tevt[1]);

  a_r9_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_q) |-> (flt_q == $past(flt_d)));

endmodule

bind ext_irq_ctrl eirq_checker u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .irq  (irq_o),
  .vec  (vec_o),
  .en   (en_q),
  .mode (mode_q),
  .tevt (tmr_evt_o),
  .flt_q(det_lvl[ext_irq_pkg::FILT_LINE]),
  .flt_d(syn_lvl[ext_irq_pkg::FILT_LINE])
);

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;

  localparam logic [2:0] M_RISE = 3'd0, M_FALL = 3'd1, M_BOTH = 3'd2,
                         M_HIGH = 3'd3, M_LOW  = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pin;
  logic       we;
  logic [1:0] addr;
  logic [5:0] wdata;
  logic       ack;
  logic [7:0] ackv;
  logic       irq;
  logic [7:0] vec;
  logic [1:0] tevt;
  logic       wake;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(pin), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .ack_i(ack), .ack_vec_i(ackv),
    .irq_o(irq), .vec_o(vec), .tmr_evt_o(tevt), .wake_o(wake)
  );

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_ack(input logic [7:0] v);
    ackv = v; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_mode(input int l, input logic [2:0] m);
    wr(2'd2, {2'(l), 1'b0, m});
  endtask

  task automatic pulse3(input int len);
    pin[3] = 1'b1;
    step(len);
    pin[3] = 1'b0;
  endtask

  function automatic logic [7:0] vexp(input int l);
    return 8'(3 + 8 * l);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = '0; we = 1'b0; addr = '0; wdata = '0; ack = 1'b0; ackv = '0;
    step(3);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 vec", vec, 8'h00);
    chk("R1 tevt", {6'd0, tevt}, 8'd0);
    chk("R1 wake", {7'd0, wake}, 8'd0);

    // R3 R5 R6 sweep over every supported mode of every line
    for (int l = 0; l < 4; l++) begin
      for (int mi = 0; mi < 5; mi++) begin
        logic [2:0] m;
        bit ok, e0, e_r, e_a, e_f;
        m  = 3'(mi);
        ok = (l < 2) ? (m != M_BOTH) : (m <= M_BOTH);
        if (ok) begin
          e0  = (m == M_LOW);
          e_r = (m == M_RISE) || (m == M_BOTH) || (m == M_HIGH);
          e_a = (m == M_HIGH);
          e_f = (m == M_FALL) || (m == M_BOTH) || (m == M_LOW);
          pin = '0;
          wr(2'd0, 6'd0);
          set_mode(l, m);
          step(8);
          do_ack(vexp(l));
          step(2);
          wr(2'd0, 6'(1 << l));
          step(1);
          chk($sformatf("R3 line%0d mode%0d idle", l, m), {7'd0, irq}, {7'd0, e0});
          pin[l] = 1'b1;
          step(6);
          chk($sformatf("R3 line%0d mode%0d rise", l, m), {7'd0, irq}, {7'd0, e_r});
          if (e_r) chk($sformatf("R8 vec line%0d", l), vec, vexp(l));
          do_ack(vexp(l));
          step(2);
          chk($sformatf("R5 R6 line%0d mode%0d after ack", l, m), {7'd0, irq}, {7'd0, e_a});
          pin[l] = 1'b0;
          step(6);
          chk($sformatf("R3 line%0d mode%0d fall", l, m), {7'd0, irq}, {7'd0, e_f});
          do_ack(vexp(l));
          step(2);
        end
      end
    end

    // reset all modes to rising, clear everything
    pin = '0;
    wr(2'd0, 6'd0);
    for (int l = 0; l < 4; l++) set_mode(l, M_RISE);
    step(8);
    for (int l = 0; l < 4; l++) do_ack(vexp(l));

    // R2 edge latency, line 0
    wr(2'd0, 6'b0001);
    pin[0] = 1'b1;
    step(2);
    chk("R2 edge not yet", {7'd0, irq}, 8'd0);
    step(1);
    chk("R2 edge due", {7'd0, irq}, 8'd1);
    do_ack(vexp(0));
    pin[0] = 1'b0;
    step(4);

    // R2 level latency, line 1 high mode
    set_mode(1, M_HIGH);
    wr(2'd0, 6'b0010);
    pin[1] = 1'b1;
    step(1);
    chk("R2 level not yet", {7'd0, irq}, 8'd0);
    step(1);
    chk("R2 level due", {7'd0, irq}, 8'd1);
    // R12 wake from a level request
    chk("R12 wake level", {7'd0, wake}, 8'd1);
    pin[1] = 1'b0;
    step(4);
    set_mode(1, M_RISE);

    // R9 line 3 latency at 1/1
    wr(2'd0, 6'b1000);
    pin[3] = 1'b1;
    step(4);
    chk("R9 latency not yet", {7'd0, irq}, 8'd0);
    step(1);
    chk("R9 latency due", {7'd0, irq}, 8'd1);
    do_ack(vexp(3));
    pin[3] = 1'b0;
    step(8);

    // R9 pulse widths at 1/1
    pulse3(1);
    step(10);
    chk("R9 1-cycle dropped", {7'd0, irq}, 8'd0);
    pulse3(2);
    step(10);
    chk("R9 2-cycle kept", {7'd0, irq}, 8'd1);
    do_ack(vexp(3));
    step(8);

    // R10 rate 1/16
    wr(2'd1, 6'd1);
    pulse3(10);
    step(60);
    chk("R10 1/16 short dropped", {7'd0, irq}, 8'd0);
    pulse3(40);
    step(60);
    chk("R10 1/16 long kept", {7'd0, irq}, 8'd1);
    do_ack(vexp(3));
    step(80);

    // R10 rate 1/64
    wr(2'd1, 6'd2);
    pulse3(50);
    step(200);
    chk("R10 1/64 short dropped", {7'd0, irq}, 8'd0);
    pulse3(140);
    step(200);
    chk("R10 1/64 long kept", {7'd0, irq}, 8'd1);
    do_ack(vexp(3));
    step(200);

    // R10 code 3 ignored: a 20-cycle pulse is still dropped at 1/64
    wr(2'd1, 6'd3);
    pulse3(20);
    step(200);
    chk("R10 code3 ignored", {7'd0, irq}, 8'd0);
    wr(2'd1, 6'd0);
    step(8);
    do_ack(vexp(3));

    // R8 priority with all lines pending
    wr(2'd0, 6'b1111);
    pin = 4'hF;
    step(8);
    chk("R8 prio line0", vec, vexp(0));
    do_ack(vexp(0)); step(1);
    chk("R8 prio line1", vec, vexp(1));
    do_ack(vexp(1)); step(1);
    chk("R8 prio line2", vec, vexp(2));
    do_ack(vexp(2)); step(1);
    chk("R8 prio line3", vec, vexp(3));
    do_ack(vexp(3)); step(1);
    chk("R8 all served", {7'd0, irq}, 8'd0);
    pin = '0;
    step(8);

    // R7 R5 pending kept while masked, other-vector ack ignored
    wr(2'd0, 6'b0000);
    pin[1] = 1'b1;
    step(5);
    chk("R7 masked", {7'd0, irq}, 8'd0);
    wr(2'd0, 6'b0010);
    chk("R5 pending kept", {7'd0, irq}, 8'd1);
    chk("R12 wake pending", {7'd0, wake}, 8'd1);
    do_ack(8'h13);
    step(1);
    chk("R5 other ack ignored", {7'd0, irq}, 8'd1);
    do_ack(vexp(1));
    step(1);
    chk("R5 ack clears", {7'd0, irq}, 8'd0);
    pin[1] = 1'b0;
    step(4);

    // R4 unsupported codes ignored
    wr(2'd0, 6'b0001);
    set_mode(0, M_BOTH);
    set_mode(0, 3'd7);
    pin[0] = 1'b1;
    step(5);
    chk("R4 line0 still rising (rise)", {7'd0, irq}, 8'd1);
    do_ack(vexp(0));
    pin[0] = 1'b0;
    step(5);
    chk("R4 line0 still rising (fall)", {7'd0, irq}, 8'd0);
    set_mode(2, M_FALL);
    set_mode(2, M_HIGH);
    wr(2'd0, 6'b0100);
    pin[2] = 1'b1;
    step(5);
    chk("R4 line2 no level mode", {7'd0, irq}, 8'd0);
    pin[2] = 1'b0;
    step(5);
    chk("R4 line2 still falling", {7'd0, irq}, 8'd1);
    do_ack(vexp(2));
    // R12 line 2 alone gives no wake
    pin[2] = 1'b1;
    step(3);
    pin[2] = 1'b0;
    step(5);
    chk("R12 no wake from line2", {7'd0, wake}, 8'd0);
    do_ack(vexp(2));
    step(2);

    // R11 timer events, mask off
    wr(2'd0, 6'd0);
    set_mode(2, M_BOTH);
    pin[2] = 1'b1;
    step(2);
    chk("R11 line2 evt due", {6'd0, tevt}, 8'd1);
    step(1);
    chk("R11 line2 evt ends", {6'd0, tevt}, 8'd0);
    step(4);
    set_mode(2, M_RISE);
    pin[2] = 1'b0;
    step(2);
    chk("R11 rising mode no evt on fall", {6'd0, tevt}, 8'd0);
    step(4);
    pin[3] = 1'b1;
    step(3);
    chk("R11 line3 evt not yet", {6'd0, tevt}, 8'd0);
    step(1);
    chk("R11 line3 evt due", {6'd0, tevt}, 8'd2);
    step(1);
    chk("R11 line3 evt ends", {6'd0, tevt}, 8'd0);
    pin[3] = 1'b0;
    step(8);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule